// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces the repeated-start condition that an I2C bus master issues between two transfers without first releasing the bus. Software raises a request. If the master is otherwise idle, the sequencer runs the following steps in order:

- It pulls SCL low and lets SDA float high for one baud period.
- It lets SCL rise, waiting for any slave that stretches the clock.
- It keeps both lines high for one baud period.
- It drives SDA low while SCL stays high for one baud period.
- It pulls SCL low.

At that point both lines are left driven low, ready for the first data bit. The request clears and a completion flag rises.

Every phase is timed by a reloadable down-counter. A phase's count starts only once the line involved is seen, through a two-flop synchronizer, at the level the sequencer wants. A slow or stretching slave therefore lengthens the sequence instead of corrupting it.

While the sequence runs, the block watches for two signs that another master is using the bus. The first is SDA already low when SCL rises. The second is SCL pulled low before this block has driven SDA low. In either case the sequencer lets go of both lines, drops the request, sets a collision flag and returns to idle without completing.

Top module: `i2c_restart_seq`

## Requirements
- R1: A request pulse (`reqSet`) is accepted only while the sequencer is idle and `busBusy` is 0. Otherwise it has no effect: `reqPending` stays 0 and both line drives keep their values.
- R2: In the cycle after a request is accepted, `reqPending` is 1, `sclDriveLow` is 1 and `sdaDriveLow` is 0.
- R3: After SDA is released, SCL stays driven low for at least one baud period, where one baud period is `reloadVal`+1 cycles. SCL is released only once SDA is seen high, so while another device holds SDA low, SCL stays driven low.
- R4: After SCL is released, the both-high period of `reloadVal`+1 cycles starts counting only once SCL is seen high through the two-flop synchronizer. A slave holding SCL low delays SDA going low by the length of the hold.
- R5: SDA is driven low only while SCL is released. It stays driven low with SCL released for exactly `reloadVal`+1 cycles, after which SCL is driven low.
- R6: At completion, `reqPending` clears and `doneFlag` sets in the same cycle that SCL is driven low. Both drives then stay at 1 until the next request.
- R7: `startSeen` sets when the synchronized SDA falls while the synchronized SCL is high, and this happens before `doneFlag` sets.
- R8: If SDA is seen low when SCL is seen to rise, the block sets `collisionFlag`, releases both lines and clears `reqPending`, and `doneFlag` stays 0.
- R9: If SCL is seen low during the both-high period, before SDA is driven low, the block reacts as in R8.
- R10: A `flagClr` pulse clears `doneFlag`, `startSeen` and `collisionFlag`.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqSet | input | 1 | One-cycle request to issue a repeated start |
| busBusy | input | 1 | Another master event is in progress |
| flagClr | input | 1 | One-cycle clear of the three status flags |
| reloadVal | input | BAUD_W | Baud counter reload; period is value+1 cycles |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low; 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| reqPending | output | 1 | Request bit, cleared by hardware at end or collision |
| doneFlag | output | 1 | Completion interrupt flag |
| startSeen | output | 1 | Start condition observed on the lines |
| collisionFlag | output | 1 | Arbitration loss during the sequence |

## Verification
The hardest situations to reach from the ports are the two collision windows. Each needs another bus device to act at a precise point within a phase that this block itself times. The bench models the wired-AND bus with separate pull-down sources for a slave and for a rival master. It keeps the slave holding SCL low across the release. To catch SDA low at the SCL rise, it lowers SDA before letting SCL go. To create the second case, it waits a few cycles after the release and then pulls SCL low inside the both-high period. The same slave hold, kept on for a counted 40 cycles, checks that clock stretching extends the sequence.

// File: rtl/i2c_restart_pkg.sv
package i2c_restart_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCLDOWN,
    S_SDAUP,
    S_SCLUP,
    S_BOTHHIGH,
    S_SDADOWN
  } rsState_t;

  typedef struct packed {
    logic loadCnt;
    logic setSclLow;
    logic relScl;
    logic setSdaLow;
    logic relSda;
    logic markDone;
    logic markColl;
  } rsStrobe_t;

endpackage

// File: rtl/i2c_restart_datapath.sv
module i2c_restart_datapath
  import i2c_restart_pkg::*;
#(
  parameter int BAUD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         str,
  input  logic [BAUD_W-1:0] reloadVal,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              flagClr,
  output logic              sclS,
  output logic              sdaS,
  output logic              tmo,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              doneFlag,
  output logic              startSeen,
  output logic              collFlag
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]     sclSh, sdaSh;
  logic              sdaSPrev;
  logic [BAUD_W-1:0] cnt;
  logic              active;
  logic              startEv;

  // Line synchronizers: reset to the idle-high bus level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= sclIn;
          sdaSh <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= {sclSh[LAST-1:0], sclIn};
          sdaSh <= {sdaSh[LAST-1:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSh[LAST];
  assign sdaS = sdaSh[LAST];

  // Baud counter: one period = reloadVal + 1 cycles from the load edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (str.loadCnt) begin
      cnt    <= reloadVal;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign tmo = active && (cnt == '0);

  // Open-drain drive registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      if (str.setSclLow)   sclDriveLow <= 1'b1;
      else if (str.relScl) sclDriveLow <= 1'b0;
      if (str.setSdaLow)   sdaDriveLow <= 1'b1;
      else if (str.relSda) sdaDriveLow <= 1'b0;
    end
  end

  // Start detection on the synchronized lines
  assign startEv = sclS && sdaSPrev && !sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaSPrev  <= 1'b1;
      doneFlag  <= 1'b0;
      startSeen <= 1'b0;
      collFlag  <= 1'b0;
    end else begin
      sdaSPrev <= sdaS;
      if (str.markDone)  doneFlag  <= 1'b1;
      else if (flagClr)  doneFlag  <= 1'b0;
      if (startEv)       startSeen <= 1'b1;
      else if (flagClr)  startSeen <= 1'b0;
      if (str.markColl)  collFlag  <= 1'b1;
      else if (flagClr)  collFlag  <= 1'b0;
    end
  end

  // R5: SDA may only start being driven low while this block releases SCL
  a_r5_sda_low_only_scl_released: assert property (
    @(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclDriveLow);

endmodule

// File: rtl/i2c_restart_ctrl.sv
module i2c_restart_ctrl
  import i2c_restart_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqSet,
  input  logic      busBusy,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic      tmo,
  output rsStrobe_t str,
  output logic      reqPending
);

  rsState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    str      = '0;
    unique case (state)
      S_IDLE: begin
        if (reqSet && !busBusy) begin
          str.setSclLow = 1'b1;
          str.relSda    = 1'b1;
          stateNxt      = S_SCLDOWN;
        end
      end
      S_SCLDOWN: begin
        if (!sclS) begin
          str.loadCnt = 1'b1;
          stateNxt    = S_SDAUP;
        end
      end
      S_SDAUP: begin
        if (tmo) begin
          if (sdaS) begin
            str.relScl = 1'b1;
            stateNxt   = S_SCLUP;
          end else begin
            str.loadCnt = 1'b1;
          end
        end
      end
      S_SCLUP: begin
        if (sclS) begin
          if (!sdaS) begin
            str.markColl = 1'b1;
            str.relScl   = 1'b1;
            str.relSda   = 1'b1;
            stateNxt     = S_IDLE;
          end else begin
            str.loadCnt = 1'b1;
            stateNxt    = S_BOTHHIGH;
          end
        end
      end
      S_BOTHHIGH: begin
        if (!sclS) begin
          str.markColl = 1'b1;
          str.relScl   = 1'b1;
          str.relSda   = 1'b1;
          stateNxt     = S_IDLE;
        end else if (tmo) begin
          str.setSdaLow = 1'b1;
          str.loadCnt   = 1'b1;
          stateNxt      = S_SDADOWN;
        end
      end
      S_SDADOWN: begin
        if (tmo) begin
          str.setSclLow = 1'b1;
          str.markDone  = 1'b1;
          stateNxt      = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign reqPending = (state != S_IDLE);

  // R1: a request while another bus event runs leaves the sequencer idle
  a_r1_busy_ignored: assert property (
    @(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqSet && busBusy) |=> (state == S_IDLE));

  // R3: SDA still low at the end of the release phase keeps the sequencer there
  a_r3_scl_held_for_sda: assert property (
    @(posedge clk) disable iff (!rstN)
    (state == S_SDAUP && tmo && !sdaS) |=> (state == S_SDAUP));

endmodule

// File: rtl/i2c_restart_seq.sv
module i2c_restart_seq
  import i2c_restart_pkg::*;
#(
  parameter int BAUD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqSet,
  input  logic              busBusy,
  input  logic              flagClr,
  input  logic [BAUD_W-1:0] reloadVal,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              reqPending,
  output logic              doneFlag,
  output logic              startSeen,
  output logic              collisionFlag
);

  rsStrobe_t str;
  logic      sclS, sdaS, tmo;

  i2c_restart_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqSet     (reqSet),
    .busBusy    (busBusy),
    .sclS       (sclS),
    .sdaS       (sdaS),
    .tmo        (tmo),
    .str        (str),
    .reqPending (reqPending)
  );

  i2c_restart_datapath #(
    .BAUD_W      (BAUD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .str         (str),
    .reloadVal   (reloadVal),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .flagClr     (flagClr),
    .sclS        (sclS),
    .sdaS        (sdaS),
    .tmo         (tmo),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .doneFlag    (doneFlag),
    .startSeen   (startSeen),
    .collFlag    (collisionFlag)
  );

  // R6: completion leaves both lines pulled low and the request dropped
  a_r6_done_holds_lines: assert property (
    @(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (sclDriveLow && sdaDriveLow && !reqPending));

  // R8 and R9: on arbitration loss both lines are let go and the request drops
  a_r8_coll_releases: assert property (
    @(posedge clk) disable iff (!rstN)
    $rose(collisionFlag) |-> (!sclDriveLow && !sdaDriveLow && !reqPending));

endmodule

// File: tb/i2c_restart_seq_test.sv
`timescale 1ns/1ps
module i2c_restart_seq_test;

  localparam int BW  = 8;
  localparam int RLD = 9;
  localparam int PER = RLD + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqSet = 1'b0, busBusy = 1'b0, flagClr = 1'b0;
  logic [BW-1:0] reloadVal = BW'(RLD);
  logic slaveSclLow = 1'b0, rivalSdaLow = 1'b0;
  logic sclLine, sdaLine;
  logic sclDriveLow, sdaDriveLow, reqPending, doneFlag, startSeen, collisionFlag;

  int checks = 0;
  int errors = 0;
  logic sawStartEarly = 1'b0;

  always #4 clk = ~clk;

  assign sclLine = ~sclDriveLow & ~slaveSclLow;
  assign sdaLine = ~sdaDriveLow & ~rivalSdaLow;

  i2c_restart_seq #(.BAUD_W(BW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .busBusy(busBusy),
    .flagClr(flagClr), .reloadVal(reloadVal), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .reqPending(reqPending),
    .doneFlag(doneFlag), .startSeen(startSeen), .collisionFlag(collisionFlag)
  );

  always @(negedge clk) if (startSeen && !doneFlag) sawStartEarly <= 1'b1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseReq();
    reqSet = 1'b1; tick(1); reqSet = 1'b0;
  endtask

  task automatic clearFlags();
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
  endtask

  task automatic waitSclRelease();
    for (int i = 0; i < 1000 && sclDriveLow; i++) tick(1);
  endtask

  task automatic testReset();
    tick(1);
    check("R11 sclDriveLow", sclDriveLow, 0);
    check("R11 sdaDriveLow", sdaDriveLow, 0);
    check("R11 reqPending", reqPending, 0);
    check("R11 flags", {doneFlag, startSeen, collisionFlag}, 0);
  endtask

  task automatic testBusyIgnored();
    busBusy = 1'b1;
    pulseReq();
    tick(20);
    check("R1 reqPending while busy", reqPending, 0);
    check("R1 sclDriveLow while busy", sclDriveLow, 0);
    check("R1 sdaDriveLow while busy", sdaDriveLow, 0);
    busBusy = 1'b0;
  endtask

  task automatic testNormal();
    int n1, n2, n3;
    n1 = 0; n2 = 0; n3 = 0;
    sawStartEarly = 1'b0;
    pulseReq();
    check("R2 reqPending", reqPending, 1);
    check("R2 sclDriveLow", sclDriveLow, 1);
    check("R2 sdaDriveLow", sdaDriveLow, 0);
    for (int i = 0; i < 1000 && sclDriveLow; i++) begin n1++; tick(1); end
    checkRange("R3 scl low after sda release", n1, PER, PER + 5);
    for (int i = 0; i < 1000 && !sdaDriveLow; i++) begin n2++; tick(1); end
    checkRange("R4 scl release to sda low", n2, PER + 1, PER + 5);
    for (int i = 0; i < 1000 && sdaDriveLow && !sclDriveLow; i++) begin n3++; tick(1); end
    check("R5 sda low with scl high", n3, PER);
    check("R6 doneFlag", doneFlag, 1);
    check("R6 reqPending cleared", reqPending, 0);
    check("R6 both driven low", {sclDriveLow, sdaDriveLow}, 2'b11);
    check("R7 startSeen", startSeen, 1);
    check("R7 start before done", sawStartEarly, 1);
    tick(10);
    check("R6 lines still held", {sclDriveLow, sdaDriveLow}, 2'b11);
  endtask

  task automatic testFlagClear();
    clearFlags();
    check("R10 flags cleared", {doneFlag, startSeen, collisionFlag}, 0);
  endtask

  task automatic testSdaHeld();
    rivalSdaLow = 1'b1;
    pulseReq();
    tick(5 * PER);
    check("R3 scl held while sda low", sclDriveLow, 1);
    check("R3 still pending", reqPending, 1);
    rivalSdaLow = 1'b0;
    for (int i = 0; i < 1000 && !doneFlag; i++) tick(1);
    check("R3 completes after sda freed", doneFlag, 1);
    clearFlags();
  endtask

  task automatic testStretch();
    int n;
    n = 0;
    slaveSclLow = 1'b1;
    pulseReq();
    waitSclRelease();
    for (int i = 0; i < 1000 && !sdaDriveLow; i++) begin
      if (n == 40) slaveSclLow = 1'b0;
      n++;
      tick(1);
    end
    checkRange("R4 stretched both-high", n, 40 + PER, 40 + PER + 6);
    for (int i = 0; i < 1000 && !doneFlag; i++) tick(1);
    check("R4 done after stretch", doneFlag, 1);
    clearFlags();
  endtask

  task automatic testCollRise();
    slaveSclLow = 1'b1;
    pulseReq();
    waitSclRelease();
    tick(3);
    rivalSdaLow = 1'b1;
    tick(3);
    slaveSclLow = 1'b0;
    for (int i = 0; i < 20 && !collisionFlag; i++) tick(1);
    check("R8 collisionFlag", collisionFlag, 1);
    check("R8 lines released", {sclDriveLow, sdaDriveLow}, 0);
    check("R8 reqPending cleared", reqPending, 0);
    check("R8 no doneFlag", doneFlag, 0);
    rivalSdaLow = 1'b0;
    tick(4);
    clearFlags();
  endtask

  task automatic testCollLow();
    pulseReq();
    waitSclRelease();
    tick(6);
    slaveSclLow = 1'b1;
    for (int i = 0; i < 20 && !collisionFlag; i++) tick(1);
    check("R9 collisionFlag", collisionFlag, 1);
    check("R9 lines released", {sclDriveLow, sdaDriveLow}, 0);
    check("R9 reqPending cleared", reqPending, 0);
    check("R9 no doneFlag", doneFlag, 0);
    slaveSclLow = 1'b0;
    tick(4);
    clearFlags();
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    testReset();
    testBusyIgnored();
    testNormal();
    testFlagClear();
    testSdaHeld();
    testStretch();
    testCollRise();
    testCollLow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule